// File: doc/BRIEF.md
# Audio Effect Multiply-Accumulate Datapath

This block is the arithmetic core of a stepped audio effect engine. Each time `step_en` is high at a rising clock edge, it performs one instruction step. It picks a 24-bit X operand and a 13-bit Y operand, multiplies them, and scales the product down by 2^10. It can then add or subtract a B operand, and it stores the 26-bit result in an accumulator.

In the same step, the accumulator value from the previous step passes through an output shifter. The shift mode is chosen per step, and each mode handles overflow in its own way. The shifter result feeds four destinations:
- a 128-entry temporary register file, addressed relative to an externally supplied ring counter;
- a fractional register;
- an address register;
- a bank of sixteen 16-bit effect output slots.

The memory write word is taken from the same shifter value.

The surrounding sequencer supplies the instruction fields, the input bus, the per-step coefficient and the ring counter. Instruction fetch and memory addressing lie outside the block.

Top module: `fx_mac_core`

## Requirements
- R1: The temporary entry that is read is `(ring_ctr + t_rd_ofs) mod 128`. The entry that is written is `(ring_ctr + t_wr_ofs) mod 128`.
- R2: The X operand is `din` when `x_sel` = 1, and the temporary entry that was read when `x_sel` = 0. Both are 24-bit two's complement.
- R3: The Y operand is set by `y_sel`, and all values are treated as signed unless noted:
  - 0 selects `frac_q` (13-bit signed);
  - 1 selects `coef[15:3]`;
  - 2 selects `yreg_q[18:6]`;
  - 3 selects `yreg_q[11:0]`, zero-extended and therefore non-negative.
- R4: The scaled product is the signed X×Y product arithmetically shifted right by 10, keeping its low 26 bits. `acc_q` loads the step result only on a step edge and holds otherwise.
- R5: When `add_zero` = 0, B is added to the scaled product, or subtracted from it when `add_neg` = 1. B is `acc_q` when `b_sel` = 1, and the read temporary value times 4 when `b_sel` = 0. The sum wraps to 26 bits. When `add_zero` = 1, the result is the scaled product alone.
- R6: In shift mode 0, `shift_out` is `acc_q` arithmetically shifted right by 2, clamped to the range [-524288, +524288].
- R7: In shift mode 1, `shift_out` is `acc_q` arithmetically shifted right by 1, clamped to the range [-524288, +524287].
- R8: In shift mode 2, `shift_out` is `acc_q` shifted right by 1, wrapped to 24 bits. In shift mode 3, `shift_out` is `acc_q` shifted right by 1 and then left by 2, wrapped to 24 bits.
- R9: `mem_wdata` is `shift_out[23:8]`. On a step with `fx_wr_en` = 1, slot `fx_slot` takes `shift_out[19:4]`. `fx_rd_data` returns the slot named by `fx_rd_slot`.
- R10: When `frac_load` = 1, `frac_q` loads `shift_out[23:11]` in mode 3, and `{0, shift_out[11:0]}` in the other modes. When `addr_load` = 1, `addr_q` loads `shift_out[23:16]` sign-extended to 12 bits in mode 3, and `shift_out[23:12]` in the other modes.
- R11: On a step with `y_load` = 1, `yreg_q` captures `din[22:4]`. Otherwise it holds.
- R12: When `t_wr_en` = 1, a step writes `shift_out` into the temporary file at the end of the step. A read of the same entry in that step still sees the old value.
- R13: Reset clears the accumulator, the Y, fractional and address registers, all effect slots and all temporary entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Executes one step at this edge |
| din | input | 24 | Input bus sample |
| coef | input | 16 | Per-step coefficient |
| ring_ctr | input | 7 | Ring counter for temporary addressing |
| x_sel | input | 1 | X operand source |
| y_sel | input | 2 | Y operand source |
| t_rd_ofs | input | 7 | Temporary read offset |
| t_wr_ofs | input | 7 | Temporary write offset |
| t_wr_en | input | 1 | Temporary write enable |
| add_zero | input | 1 | Suppresses the B term |
| add_neg | input | 1 | Subtracts B |
| b_sel | input | 1 | B source: accumulator or temporary |
| y_load | input | 1 | Loads the Y register from `din` |
| frac_load | input | 1 | Loads the fractional register |
| addr_load | input | 1 | Loads the address register |
| shift_mode | input | 2 | Output shifter mode |
| fx_wr_en | input | 1 | Writes an effect slot |
| fx_slot | input | 4 | Effect slot to write |
| fx_rd_slot | input | 4 | Effect slot to read |
| acc_q | output | 26 | Accumulator |
| shift_out | output | 24 | Shifter result of `acc_q` |
| mem_wdata | output | 16 | Memory write word |
| fx_rd_data | output | 16 | Selected effect slot |
| frac_q | output | 13 | Fractional register |
| addr_q | output | 12 | Address register |
| yreg_q | output | 19 | Y register |

## Verification
The accumulator and the Y, fractional, address, slot and temporary registers all change on the one rising edge where `step_en` is sampled high. `shift_out` and `mem_wdata` are combinational from `acc_q` and `shift_mode`, so they settle in that same cycle.

The driver raises `step_en` for exactly one edge and holds the step's fields until the next step. It queues the predicted state, and the monitor compares it at the following falling edge, half a period after the update.

A temporary entry written in one step is first visible as an operand on the next step. The bench therefore checks the write-then-read order across two consecutive steps.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;
  localparam int FX_DW  = 24;  // data path / temporary width
  localparam int FX_YW  = 13;  // Y operand width
  localparam int FX_CW  = 16;  // coefficient width
  localparam int FX_PSH = 10;  // product down-scale
  localparam int FX_TAW = 7;   // temporary address width
  localparam int FX_SLW = 4;   // effect slot index width
  localparam int FX_OW  = 16;  // effect / memory word width

  typedef enum logic [1:0] {
    SH_SAT_Q2     = 2'd0,
    SH_SAT_Q1     = 2'd1,
    SH_WRAP_Q1    = 2'd2,
    SH_WRAP_SCALE = 2'd3
  } shmode_e;

  typedef enum logic [1:0] {
    YS_FRAC = 2'd0,
    YS_COEF = 2'd1,
    YS_YHI  = 2'd2,
    YS_YLO  = 2'd3
  } ysrc_e;
endpackage

// File: rtl/fxmac_temp_file.sv
module fxmac_temp_file #(
  parameter int DW = 24,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring,
  input  logic [AW-1:0] rd_ofs,
  input  logic [AW-1:0] wr_ofs,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] rd_idx;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] mem [DEPTH];

  // rotated addressing, wraps modulo DEPTH
  always_comb begin
    rd_idx = ring + rd_ofs;
    wr_idx = ring + wr_ofs;
  end

  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // R12: the write lands at the step edge
  a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/fxmac_mad.sv
module fxmac_mad
  import fxmac_pkg::*;
#(
  parameter int DW   = FX_DW,
  parameter int YW   = FX_YW,
  parameter int CW   = FX_CW,
  parameter int PSH  = FX_PSH,
  parameter int ACCW = DW + 2,
  parameter int YRW  = DW - 5
) (
  input  logic            x_sel,
  input  logic [1:0]      y_sel,
  input  logic [DW-1:0]   din,
  input  logic [DW-1:0]   temp_rd,
  input  logic [YW-1:0]   frac_q,
  input  logic [CW-1:0]   coef,
  input  logic [YRW-1:0]  yreg_q,
  input  logic [ACCW-1:0] acc_q,
  input  logic            add_zero,
  input  logic            add_neg,
  input  logic            b_sel,
  output logic [ACCW-1:0] mad_nxt
);
  localparam int PW = DW + YW;

  logic signed [DW-1:0]   x_op;
  logic signed [YW-1:0]   y_op;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] scaled;
  logic signed [ACCW-1:0] b_op;

  always_comb begin
    x_op = x_sel ? din : temp_rd;
    unique case (ysrc_e'(y_sel))
      YS_FRAC: y_op = frac_q;
      YS_COEF: y_op = coef[CW-1 -: YW];
      YS_YHI:  y_op = yreg_q[YRW-1 -: YW];
      default: y_op = {1'b0, yreg_q[YW-2:0]};
    endcase
    prod   = x_op * y_op;
    scaled = prod[PSH+ACCW-1:PSH];
    b_op   = b_sel ? acc_q : {temp_rd, 2'b00};
    if (add_zero)     mad_nxt = scaled;
    else if (add_neg) mad_nxt = scaled - b_op;
    else              mad_nxt = scaled + b_op;
  end
endmodule

// File: rtl/fxmac_shifter.sv
module fxmac_shifter
  import fxmac_pkg::*;
#(
  parameter int DW   = FX_DW,
  parameter int YW   = FX_YW,
  parameter int OW   = FX_OW,
  parameter int ACCW = DW + 2,
  parameter int ADW  = DW / 2
) (
  input  logic [ACCW-1:0] acc,
  input  logic [1:0]      mode,
  output logic [DW-1:0]   shv,
  output logic [OW-1:0]   fx_val,
  output logic [OW-1:0]   mem_val,
  output logic [YW-1:0]   frac_val,
  output logic [ADW-1:0]  addr_val
);
  localparam int LIM = 1 << (DW - 5);
  localparam logic signed [ACCW-1:0] P_LIM  = ACCW'(LIM);
  localparam logic signed [ACCW-1:0] P_LIM1 = ACCW'(LIM - 1);
  localparam logic signed [ACCW-1:0] N_LIM  = ACCW'(-LIM);
  localparam int SX = ADW - (DW - 16);

  logic signed [ACCW-1:0] a;
  logic signed [ACCW-1:0] h1;
  logic signed [ACCW-1:0] h2;

  always_comb begin
    a  = acc;
    h1 = a >>> 1;
    h2 = a >>> 2;
    unique case (shmode_e'(mode))
      SH_SAT_Q2: begin
        if (h2 > P_LIM)      shv = P_LIM[DW-1:0];
        else if (h2 < N_LIM) shv = N_LIM[DW-1:0];
        else                 shv = h2[DW-1:0];
      end
      SH_SAT_Q1: begin
        if (h1 > P_LIM1)     shv = P_LIM1[DW-1:0];
        else if (h1 < N_LIM) shv = N_LIM[DW-1:0];
        else                 shv = h1[DW-1:0];
      end
      SH_WRAP_Q1: shv = h1[DW-1:0];
      default:    shv = {h1[DW-3:0], 2'b00};
    endcase
  end

  always_comb begin
    fx_val  = shv[OW+3:4];
    mem_val = shv[DW-1 -: OW];
    if (shmode_e'(mode) == SH_WRAP_SCALE) begin
      frac_val = shv[DW-1 -: YW];
      addr_val = {{SX{shv[DW-1]}}, shv[DW-1:16]};
    end else begin
      frac_val = {1'b0, shv[YW-2:0]};
      addr_val = shv[DW-1 -: ADW];
    end
  end
endmodule

// File: rtl/fx_mac_core.sv
module fx_mac_core
  import fxmac_pkg::*;
#(
  parameter int DW   = FX_DW,
  parameter int YW   = FX_YW,
  parameter int CW   = FX_CW,
  parameter int TAW  = FX_TAW,
  parameter int SLW  = FX_SLW,
  parameter int OW   = FX_OW,
  parameter int ACCW = DW + 2,
  parameter int YRW  = DW - 5,
  parameter int ADW  = DW / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic [DW-1:0]   din,
  input  logic [CW-1:0]   coef,
  input  logic [TAW-1:0]  ring_ctr,
  input  logic            x_sel,
  input  logic [1:0]      y_sel,
  input  logic [TAW-1:0]  t_rd_ofs,
  input  logic [TAW-1:0]  t_wr_ofs,
  input  logic            t_wr_en,
  input  logic            add_zero,
  input  logic            add_neg,
  input  logic            b_sel,
  input  logic            y_load,
  input  logic            frac_load,
  input  logic            addr_load,
  input  logic [1:0]      shift_mode,
  input  logic            fx_wr_en,
  input  logic [SLW-1:0]  fx_slot,
  input  logic [SLW-1:0]  fx_rd_slot,
  output logic [ACCW-1:0] acc_q,
  output logic [DW-1:0]   shift_out,
  output logic [OW-1:0]   mem_wdata,
  output logic [OW-1:0]   fx_rd_data,
  output logic [YW-1:0]   frac_q,
  output logic [ADW-1:0]  addr_q,
  output logic [YRW-1:0]  yreg_q
);
  localparam int NSLOT = 1 << SLW;

  logic [DW-1:0]   temp_rd;
  logic [ACCW-1:0] mad_nxt;
  logic [OW-1:0]   fx_val;
  logic [YW-1:0]   frac_val;
  logic [ADW-1:0]  addr_val;

  logic [ACCW-1:0] acc_d;
  logic [YRW-1:0]  yreg_d;
  logic [YW-1:0]   frac_d;
  logic [ADW-1:0]  addr_d;
  logic [OW-1:0]   fx_q [NSLOT];
  logic [OW-1:0]   fx_d [NSLOT];

  fxmac_temp_file #(.DW(DW), .AW(TAW)) u_temp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ring    (ring_ctr),
    .rd_ofs  (t_rd_ofs),
    .wr_ofs  (t_wr_ofs),
    .wr_en   (step_en && t_wr_en),
    .wr_data (shift_out),
    .rd_data (temp_rd)
  );

  fxmac_mad #(.DW(DW), .YW(YW), .CW(CW), .ACCW(ACCW), .YRW(YRW)) u_mad (
    .x_sel    (x_sel),
    .y_sel    (y_sel),
    .din      (din),
    .temp_rd  (temp_rd),
    .frac_q   (frac_q),
    .coef     (coef),
    .yreg_q   (yreg_q),
    .acc_q    (acc_q),
    .add_zero (add_zero),
    .add_neg  (add_neg),
    .b_sel    (b_sel),
    .mad_nxt  (mad_nxt)
  );

  fxmac_shifter #(.DW(DW), .YW(YW), .OW(OW), .ACCW(ACCW), .ADW(ADW)) u_shf (
    .acc      (acc_q),
    .mode     (shift_mode),
    .shv      (shift_out),
    .fx_val   (fx_val),
    .mem_val  (mem_wdata),
    .frac_val (frac_val),
    .addr_val (addr_val)
  );

  // next state
  always_comb begin
    acc_d  = acc_q;
    yreg_d = yreg_q;
    frac_d = frac_q;
    addr_d = addr_q;
    for (int i = 0; i < NSLOT; i++) fx_d[i] = fx_q[i];
    if (step_en) begin
      acc_d = mad_nxt;
      if (y_load)    yreg_d = din[DW-2:4];
      if (frac_load) frac_d = frac_val;
      if (addr_load) addr_d = addr_val;
      if (fx_wr_en)  fx_d[fx_slot] = fx_val;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      yreg_q <= '0;
      frac_q <= '0;
      addr_q <= '0;
      for (int i = 0; i < NSLOT; i++) fx_q[i] <= '0;
    end else begin
      acc_q  <= acc_d;
      yreg_q <= yreg_d;
      frac_q <= frac_d;
      addr_q <= addr_d;
      for (int i = 0; i < NSLOT; i++) fx_q[i] <= fx_d[i];
    end
  end

  assign fx_rd_data = fx_q[fx_rd_slot];

  // R4: accumulator holds without a step
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(acc_q));

  // R6: mode 0 output stays inside its clamp window
  a_r6_clamp_q2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_mode == 2'd0) |-> ($signed(shift_out) <= 24'sd524288 &&
                              $signed(shift_out) >= -24'sd524288));

  // R7: mode 1 output stays inside its clamp window
  a_r7_clamp_q1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_mode == 2'd1) |-> ($signed(shift_out) <= 24'sd524287 &&
                              $signed(shift_out) >= -24'sd524288));

  // R11: Y register holds unless loaded
  a_r11_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en && y_load) |=> $stable(yreg_q));

  // R10: outside mode 3 the fractional load is non-negative
  a_r10_frac_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && frac_load && shift_mode != 2'd3) |=> !frac_q[YW-1]);

  // R10: in mode 3 the address load is sign-extended
  a_r10_addr_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && addr_load && shift_mode == 2'd3) |=>
      (addr_q[ADW-1:8] == '0 || addr_q[ADW-1:8] == '1));
endmodule

// File: tb/tb_fx_mac_core.sv
module tb_fx_mac_core;
  typedef struct packed {
    logic        x_sel;
    logic [1:0]  y_sel;
    logic [6:0]  tra;
    logic [6:0]  twa;
    logic        twt;
    logic        zero;
    logic        neg;
    logic        bsel;
    logic        yld;
    logic        fld;
    logic        ald;
    logic        fxw;
    logic [1:0]  mode;
    logic [3:0]  slot;
    logic [23:0] din;
    logic [15:0] coef;
    logic [6:0]  ring;
  } op_t;

  typedef struct {
    string       tag;
    logic [25:0] acc;
    logic [23:0] shv;
    logic [15:0] mwd;
    logic [15:0] fx;
    logic [12:0] frac;
    logic [11:0] addr;
    logic [18:0] y;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic step_en = 0;
  logic [23:0] din = 0;
  logic [15:0] coef = 0;
  logic [6:0] ring_ctr = 0, t_rd_ofs = 0, t_wr_ofs = 0;
  logic x_sel = 0, t_wr_en = 0, add_zero = 1, add_neg = 0, b_sel = 0;
  logic y_load = 0, frac_load = 0, addr_load = 0, fx_wr_en = 0;
  logic [1:0] y_sel = 0, shift_mode = 0;
  logic [3:0] fx_slot = 0, fx_rd_slot = 0;
  logic [25:0] acc_q;
  logic [23:0] shift_out;
  logic [15:0] mem_wdata, fx_rd_data;
  logic [12:0] frac_q;
  logic [11:0] addr_q;
  logic [18:0] yreg_q;

  int vectors = 0;
  int miscompares = 0;
  exp_t sb[$];

  // bench model state
  logic [25:0] m_acc;
  logic [23:0] m_temp [128];
  logic [12:0] m_frac;
  logic [11:0] m_addr;
  logic [18:0] m_y;
  logic [15:0] m_fx [16];

  always #10 clk = ~clk;

  fx_mac_core dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .din(din), .coef(coef),
    .ring_ctr(ring_ctr), .x_sel(x_sel), .y_sel(y_sel), .t_rd_ofs(t_rd_ofs),
    .t_wr_ofs(t_wr_ofs), .t_wr_en(t_wr_en), .add_zero(add_zero),
    .add_neg(add_neg), .b_sel(b_sel), .y_load(y_load), .frac_load(frac_load),
    .addr_load(addr_load), .shift_mode(shift_mode), .fx_wr_en(fx_wr_en),
    .fx_slot(fx_slot), .fx_rd_slot(fx_rd_slot), .acc_q(acc_q),
    .shift_out(shift_out), .mem_wdata(mem_wdata), .fx_rd_data(fx_rd_data),
    .frac_q(frac_q), .addr_q(addr_q), .yreg_q(yreg_q)
  );

  function automatic logic [23:0] shf(input logic [25:0] a, input logic [1:0] m);
    logic signed [63:0] s, t;
    s = 64'($signed(a));
    case (m)
      2'd0: begin t = s >>> 2; if (t > 524288) t = 524288; if (t < -524288) t = -524288; end
      2'd1: begin t = s >>> 1; if (t > 524287) t = 524287; if (t < -524288) t = -524288; end
      2'd2: t = s >>> 1;
      default: t = (s >>> 1) * 4;
    endcase
    return t[23:0];
  endfunction

  function automatic logic [25:0] mac(input op_t o);
    logic signed [63:0] x, y, p, b, r;
    logic [23:0] tv;
    tv = m_temp[7'(o.ring + o.tra)];
    x = o.x_sel ? 64'($signed(o.din)) : 64'($signed(tv));
    case (o.y_sel)
      2'd0: y = 64'($signed(m_frac));
      2'd1: y = 64'($signed(o.coef[15:3]));
      2'd2: y = 64'($signed(m_y[18:6]));
      default: y = 64'(m_y[11:0]);
    endcase
    p = (x * y) >>> 10;
    p = 64'($signed(p[25:0]));
    b = o.bsel ? 64'($signed(m_acc)) : 64'($signed(tv)) * 4;
    if (o.zero) r = p;
    else if (o.neg) r = p - b;
    else r = p + b;
    return r[25:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // monitor: compares queued predictions half a period after the update edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "acc_q", 32'(acc_q), 32'(e.acc));
        chk(e.tag, "shift_out", 32'(shift_out), 32'(e.shv));
        chk(e.tag, "mem_wdata", 32'(mem_wdata), 32'(e.mwd));
        chk(e.tag, "fx_rd_data", 32'(fx_rd_data), 32'(e.fx));
        chk(e.tag, "frac_q", 32'(frac_q), 32'(e.frac));
        chk(e.tag, "addr_q", 32'(addr_q), 32'(e.addr));
        chk(e.tag, "yreg_q", 32'(yreg_q), 32'(e.y));
      end
    end
  end

  task automatic apply(input op_t o, input logic en);
    din = o.din; coef = o.coef; ring_ctr = o.ring; x_sel = o.x_sel;
    y_sel = o.y_sel; t_rd_ofs = o.tra; t_wr_ofs = o.twa; t_wr_en = o.twt;
    add_zero = o.zero; add_neg = o.neg; b_sel = o.bsel; y_load = o.yld;
    frac_load = o.fld; addr_load = o.ald; shift_mode = o.mode;
    fx_wr_en = o.fxw; fx_slot = o.slot; fx_rd_slot = o.slot; step_en = en;
  endtask

  task automatic push(input string tag, input op_t o);
    exp_t e;
    logic [23:0] v;
    v = shf(m_acc, o.mode);
    e.tag = tag; e.acc = m_acc; e.shv = v; e.mwd = v[23:8];
    e.fx = m_fx[o.slot]; e.frac = m_frac; e.addr = m_addr; e.y = m_y;
    sb.push_back(e);
  endtask

  // driver: one step, model update, prediction queued
  task automatic step(input op_t o, input string tag);
    logic [23:0] v;
    logic [25:0] nxt;
    @(posedge clk); #2;
    apply(o, 1'b1);
    v = shf(m_acc, o.mode);
    nxt = mac(o);
    if (o.twt) m_temp[7'(o.ring + o.twa)] = v;
    if (o.fld) m_frac = (o.mode == 2'd3) ? v[23:11] : {1'b0, v[11:0]};
    if (o.ald) m_addr = (o.mode == 2'd3) ? {{4{v[23]}}, v[23:16]} : v[23:12];
    if (o.yld) m_y = o.din[22:4];
    if (o.fxw) m_fx[o.slot] = v[19:4];
    m_acc = nxt;
    @(posedge clk); #2;
    step_en = 0;
    push(tag, o);
  endtask

  function automatic op_t base();
    op_t o;
    o = '0;
    o.zero = 1'b1;
    o.x_sel = 1'b1;
    o.y_sel = 2'd1;
    return o;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    op_t o;
    m_acc = 0; m_frac = 0; m_addr = 0; m_y = 0;
    for (int i = 0; i < 128; i++) m_temp[i] = 0;
    for (int i = 0; i < 16; i++) m_fx[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R13: reset state
    push("R13", '0);
    @(posedge clk);

    // R3/R4: coef[15:3]=1, din=2^20 -> acc 1024
    o = base(); o.din = 24'h100000; o.coef = 16'h0008; step(o, "R3");
    // R2: negative input, Y=-1; write temp at (120+10)%128=2 (R1)
    o = base(); o.din = 24'h800000; o.coef = 16'hFFF8; o.ring = 7'd120;
    o.twa = 7'd10; o.twt = 1; o.mode = 2'd2; step(o, "R2");
    // R12: read entry 2 while overwriting it: old value used
    o = base(); o.x_sel = 0; o.coef = 16'h4000; o.tra = 7'd2; o.twa = 7'd2;
    o.twt = 1; step(o, "R12");
    // R1: (5+125)%128 = 2 sees the new value
    o = base(); o.x_sel = 0; o.coef = 16'h4000; o.ring = 7'd5; o.tra = 7'd125;
    o.mode = 2'd3; step(o, "R1");
    // R5: add accumulator, subtract accumulator, add temp*4
    o = base(); o.din = 24'd100; o.coef = 16'h4000; o.zero = 0; o.bsel = 1; step(o, "R5");
    o.neg = 1; step(o, "R5");
    o = base(); o.din = 24'd100; o.coef = 16'h4000; o.zero = 0; o.tra = 7'd2; step(o, "R5");
    o.neg = 1; step(o, "R5");
    // R4: no step -> no change despite new inputs
    o = base(); o.din = 24'h7FFFFF; o.coef = 16'h7FF8;
    @(posedge clk); #2; apply(o, 1'b0);
    repeat (2) @(posedge clk); #2; push("R4", o);
    // R6: positive and negative saturation, exact boundary, one past
    o = base(); o.din = 24'h7FFFFF; o.coef = 16'h7FF8; step(o, "R6");
    o.din = 24'h800000; step(o, "R6");
    o.din = 24'h100000; o.coef = 16'h4000; step(o, "R6");
    o.din = 24'h100002; step(o, "R6");
    o.din = 24'hF00000; step(o, "R6");
    // R7: 2^20 -> 524287; large positive and negative
    o = base(); o.mode = 2'd1; o.din = 24'h080000; o.coef = 16'h4000; step(o, "R7");
    o.din = 24'h7FFFFF; o.coef = 16'h7FF8; step(o, "R7");
    o.din = 24'h800000; step(o, "R7");
    // R8: wrap modes on a large accumulator
    o = base(); o.mode = 2'd2; o.din = 24'h7FFFFF; o.coef = 16'h7FF8; step(o, "R8");
    o.mode = 2'd3; step(o, "R8");
    o.din = 24'h812345; o.coef = 16'h3458; step(o, "R8");
    // R9: effect slot 7 written, then slot 3
    o = base(); o.mode = 2'd2; o.fxw = 1; o.slot = 4'd7; o.din = 24'h123456; o.coef = 16'h2000; step(o, "R9");
    o.slot = 4'd3; step(o, "R9");
    // R10: loads in mode 3 and mode 2, then fractional as Y
    o = base(); o.mode = 2'd3; o.fld = 1; o.ald = 1; o.din = 24'h456789; step(o, "R10");
    o.din = 24'h900000; o.coef = 16'h7FF8; step(o, "R10");
    o.mode = 2'd2; step(o, "R10");
    o = base(); o.y_sel = 2'd0; o.din = 24'h020000; step(o, "R10");
    // R11: Y load then Y high and Y low operands
    o = base(); o.yld = 1; o.din = 24'hABCDE0; step(o, "R11");
    o = base(); o.y_sel = 2'd2; o.din = 24'h001000; step(o, "R11");
    o.y_sel = 2'd3; step(o, "R11");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule